// File: doc/BRIEF.md
# Four-State Add-Compare-Select Metric Unit

This block carries the path-metric recursion of a hard-decision decoder for a rate 1/2 convolutional code with two memory bits, hence four trellis states. Each time a 2-bit received symbol is presented with a valid strobe, every state looks up its two possible predecessor states and the code symbol each incoming branch would have produced. It adds the Hamming distance between that expected symbol and the received one to the predecessor's stored metric, and keeps the smaller of the two sums as its own new metric.

The new metrics are kept in a bank of eight metric snapshots, one per trellis time step, so that a traceback stage can read any step of the current window through a read port. The same clock edge that stores the metrics also registers the index of the cheapest state and advances the time index. A symbol that arrives while the index stands at its last value starts a fresh window: the bank is wiped, the starting metrics are reloaded, and that symbol becomes the first step of the new window.

Top module: `acs4_metric_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `timeIdx`=0, `bestState`=0 and `stepDone`=0. Snapshot 0 holds metric 0 for state 0 and metric 7 for states 1, 2 and 3, and snapshots 1 to 7 hold 0 in every state.
- R2: A state is numbered by its two memory bits {newest, older}. Input bit u in state {a,b} leads to state {u,a} and emits the symbol {u^a^b, u^b}. Each state's two incoming branches and their expected symbols follow from this rule.
- R3: A state's new metric is the smaller of its two incoming sums. Each sum is the predecessor's metric in the source snapshot plus the number of differing bits between `symIn` and the branch's expected symbol. Any sum above 15 is clamped to 15.
- R4: `bestState` is the state holding the smallest new metric. When several states share that value, the lowest-numbered one is reported.
- R5: A high `symValid` with `timeIdx` below 7 reads the metrics in snapshot `timeIdx`, writes the new metrics into snapshot `timeIdx`+1 and advances `timeIdx` by one. All other snapshots keep their values.
- R6: `stepDone` is high for exactly the cycle after each clock edge that accepted a symbol, and is low otherwise.
- R7: With `symValid` low, `timeIdx`, `bestState` and every snapshot keep their values whatever `symIn` carries.
- R8: A high `symValid` with `timeIdx` equal to 7 clears snapshots 2 to 7 to 0 and reloads snapshot 0 with the starting metrics of R1. It computes the new metrics from those starting metrics, writes them into snapshot 1 and sets `timeIdx` to 1.
- R9: `rdMetrics` shows, without a clock delay, the snapshot selected by `rdTime`, with state s in bits [4s+3:4s].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | Received symbol is valid this cycle |
| symIn | input | 2 | Hard-decision received symbol |
| rdTime | input | 3 | Snapshot selected for reading |
| bestState | output | 2 | State with the smallest newest metric |
| timeIdx | output | 3 | Time step of the newest snapshot |
| stepDone | output | 1 | One-cycle pulse after an accepted symbol |
| rdMetrics | output | 16 | Four 4-bit metrics of the selected snapshot |

## Verification
A wrong branch table, a wrong distance or a wrong compare shows as a mismatched metric in the newest snapshot the cycle after the symbol that touched it. The bench reads every snapshot after every step, so a stray write or an incomplete clear at the window wrap shows within one symbol. A wrong tie-break shows only on a step where two states share the minimum; the bench sweeps every three-symbol sequence from reset, and those sequences produce such ties. Errors in the time index or the done pulse show on the first step they affect.

// File: rtl/acs4_pkg.sv
package acs4_pkg;
  localparam int NUM_STATES = 4;
  localparam int STATE_W    = $clog2(NUM_STATES);
  localparam int SYM_W      = 2;
  localparam int METRIC_W   = 4;
  localparam int NUM_SNAP   = 8;
  localparam int TIME_W     = $clog2(NUM_SNAP);
  localparam int METRIC_MAX = (1 << METRIC_W) - 1;
  localparam int INIT_FAR   = 7;
  localparam int ENTRY_W    = 2 * (STATE_W + SYM_W);

  typedef logic [METRIC_W-1:0] metric_t;
  typedef logic [STATE_W-1:0]  state_t;
  typedef logic [SYM_W-1:0]    sym_t;
  typedef logic [TIME_W-1:0]   tidx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  step;
    logic  restart;
    tidx_t srcIdx;
    tidx_t dstIdx;
  } stepCtl_t;

  // starting metric for a state at the head of a window
  function automatic metric_t initMetric(int s);
    return (s == 0) ? metric_t'(0) : metric_t'(INIT_FAR);
  endfunction

  // merged lookup: {predLow, symLow, predHigh, symHigh} per present state
  function automatic logic [ENTRY_W-1:0] predEntry(state_t s);
    logic [ENTRY_W-1:0] e;
    case (s)
      2'd0:    e = {2'd0, 2'b00, 2'd1, 2'b11};
      2'd1:    e = {2'd2, 2'b10, 2'd3, 2'b01};
      2'd2:    e = {2'd0, 2'b11, 2'd1, 2'b00};
      default: e = {2'd2, 2'b01, 2'd3, 2'b10};
    endcase
    return e;
  endfunction

  function automatic logic [METRIC_W:0] hamming(sym_t a, sym_t b);
    logic [METRIC_W:0] n;
    n = '0;
    for (int i = 0; i < SYM_W; i++) n = n + (METRIC_W+1)'(a[i] ^ b[i]);
    return n;
  endfunction
endpackage

// File: rtl/acs4_acs_unit.sv
module acs4_acs_unit
  import acs4_pkg::*;
(
  input  state_t                           presentState,
  input  sym_t                             symIn,
  input  logic [NUM_STATES*METRIC_W-1:0]   srcMetrics,
  output metric_t                          newMetric
);
  logic [ENTRY_W-1:0] entry;
  state_t predLo, predHi;
  sym_t   symLo, symHi;
  logic [METRIC_W:0] sumLo, sumHi;
  metric_t satLo, satHi;

  always_comb begin
    entry  = predEntry(presentState);
    predLo = entry[ENTRY_W-1 -: STATE_W];
    symLo  = entry[ENTRY_W-STATE_W-1 -: SYM_W];
    predHi = entry[STATE_W+SYM_W-1 -: STATE_W];
    symHi  = entry[SYM_W-1:0];
    sumLo  = {1'b0, srcMetrics[predLo*METRIC_W +: METRIC_W]} + hamming(symIn, symLo);
    sumHi  = {1'b0, srcMetrics[predHi*METRIC_W +: METRIC_W]} + hamming(symIn, symHi);
    satLo  = (sumLo > (METRIC_W+1)'(METRIC_MAX)) ? metric_t'(METRIC_MAX) : sumLo[METRIC_W-1:0];
    satHi  = (sumHi > (METRIC_W+1)'(METRIC_MAX)) ? metric_t'(METRIC_MAX) : sumHi[METRIC_W-1:0];
    // equal sums keep the lower-numbered predecessor
    newMetric = (satHi < satLo) ? satHi : satLo;
  end
endmodule

// File: rtl/acs4_ctrl.sv
module acs4_ctrl
  import acs4_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     symValid,
  output stepCtl_t ctl,
  output tidx_t    timeIdx,
  output logic     stepDone
);
  localparam tidx_t LAST_IDX = tidx_t'(NUM_SNAP - 1);
  localparam tidx_t FIRST_STEP = tidx_t'(1);

  logic atLast;

  always_comb begin
    atLast      = (timeIdx == LAST_IDX);
    ctl.step    = symValid;
    ctl.restart = symValid && atLast;
    ctl.srcIdx  = timeIdx;
    ctl.dstIdx  = atLast ? FIRST_STEP : timeIdx + tidx_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeIdx  <= '0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= symValid;
      if (symValid) timeIdx <= ctl.dstIdx;
    end
  end
endmodule

// File: rtl/acs4_datapath.sv
module acs4_datapath
  import acs4_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  stepCtl_t                       ctl,
  input  sym_t                           symIn,
  input  tidx_t                          rdTime,
  output logic [NUM_STATES*METRIC_W-1:0] rdMetrics,
  output state_t                         bestState
);
  metric_t snap [NUM_SNAP][NUM_STATES];
  logic [NUM_STATES*METRIC_W-1:0] srcFlat;
  metric_t newMetric [NUM_STATES];
  state_t  minIdx;
  metric_t minVal;

  always_comb begin
    for (int s = 0; s < NUM_STATES; s++)
      srcFlat[s*METRIC_W +: METRIC_W] = ctl.restart ? initMetric(s) : snap[ctl.srcIdx][s];
  end

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_acs
    acs4_acs_unit u_acs (
      .presentState (state_t'(g)),
      .symIn        (symIn),
      .srcMetrics   (srcFlat),
      .newMetric    (newMetric[g])
    );
  end

  // strict compare keeps the lowest-numbered state on ties
  always_comb begin
    minIdx = '0;
    minVal = newMetric[0];
    for (int s = 1; s < NUM_STATES; s++) begin
      if (newMetric[s] < minVal) begin
        minIdx = state_t'(s);
        minVal = newMetric[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_SNAP; t++)
        for (int s = 0; s < NUM_STATES; s++)
          snap[t][s] <= (t == 0) ? initMetric(s) : metric_t'(0);
      bestState <= '0;
    end else if (ctl.step) begin
      if (ctl.restart) begin
        for (int t = 0; t < NUM_SNAP; t++)
          for (int s = 0; s < NUM_STATES; s++)
            snap[t][s] <= (t == 0) ? initMetric(s) : metric_t'(0);
      end
      for (int s = 0; s < NUM_STATES; s++) snap[ctl.dstIdx][s] <= newMetric[s];
      bestState <= minIdx;
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_STATES; s++)
      rdMetrics[s*METRIC_W +: METRIC_W] = snap[rdTime][s];
  end
endmodule

// File: rtl/acs4_metric_unit.sv
module acs4_metric_unit
  import acs4_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 symValid,
  input  logic [SYM_W-1:0]                     symIn,
  input  logic [TIME_W-1:0]                    rdTime,
  output logic [STATE_W-1:0]                   bestState,
  output logic [TIME_W-1:0]                    timeIdx,
  output logic                                 stepDone,
  output logic [NUM_STATES*METRIC_W-1:0]       rdMetrics
);
  stepCtl_t ctl;

  acs4_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .symValid (symValid),
    .ctl      (ctl),
    .timeIdx  (timeIdx),
    .stepDone (stepDone)
  );

  acs4_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .symIn     (symIn),
    .rdTime    (rdTime),
    .rdMetrics (rdMetrics),
    .bestState (bestState)
  );
endmodule

// File: rtl/acs4_checker.sv
module acs4_checker
  import acs4_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         symValid,
  input logic [TIME_W-1:0]  timeIdx,
  input logic [STATE_W-1:0] bestState,
  input logic         stepDone
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (timeIdx == '0 && bestState == '0 && !stepDone));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    symValid |=> stepDone);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !symValid |=> !stepDone);

  // R5
  time_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (symValid && timeIdx != TIME_W'(NUM_SNAP-1)) |=> timeIdx == $past(timeIdx) + TIME_W'(1));

  // R8
  window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (symValid && timeIdx == TIME_W'(NUM_SNAP-1)) |=> timeIdx == TIME_W'(1));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !symValid |=> ($stable(timeIdx) && $stable(bestState)));
endmodule

bind acs4_metric_unit acs4_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .symValid  (symValid),
  .timeIdx   (timeIdx),
  .bestState (bestState),
  .stepDone  (stepDone)
);

// File: tb/acs4_metric_unit_bench.sv
module acs4_metric_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symValid = 1'b0;
  logic [1:0] symIn = 2'b00;
  logic [2:0] rdTime = 3'd0;
  logic [1:0] bestState;
  logic [2:0] timeIdx;
  logic stepDone;
  logic [15:0] rdMetrics;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int mSnap [8][4];
  int mT;
  int mBest;

  always #2 clk = ~clk;

  acs4_metric_unit u_acs4_metric_unit (
    .clk(clk), .rst(rst), .symValid(symValid), .symIn(symIn), .rdTime(rdTime),
    .bestState(bestState), .timeIdx(timeIdx), .stepDone(stepDone), .rdMetrics(rdMetrics)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int encOut(int p, int u);
    int a = (p >> 1) & 1;
    int b = p & 1;
    return ((u ^ a ^ b) << 1) | (u ^ b);
  endfunction

  function automatic int nextSt(int p, int u);
    return (u << 1) | ((p >> 1) & 1);
  endfunction

  function automatic int popc(int x);
    return (x & 1) + ((x >> 1) & 1);
  endfunction

  task automatic modelReset();
    for (int t = 0; t < 8; t++)
      for (int s = 0; s < 4; s++) mSnap[t][s] = (t == 0) ? ((s == 0) ? 0 : 7) : 0;
    mT = 0;
    mBest = 0;
  endtask

  task automatic modelStep(int sym);
    int src[4];
    int nm[4];
    int dst;
    if (mT == 7) begin
      modelReset();
      dst = 1;
    end else dst = mT + 1;
    for (int s = 0; s < 4; s++) src[s] = mSnap[(dst == 1) ? 0 : mT][s];
    for (int n = 0; n < 4; n++) begin
      nm[n] = 99;
      for (int p = 0; p < 4; p++)
        for (int u = 0; u < 2; u++)
          if (nextSt(p, u) == n) begin
            int v = src[p] + popc(sym ^ encOut(p, u));
            if (v > 15) v = 15;
            if (v < nm[n]) nm[n] = v;
          end
    end
    mBest = 0;
    for (int s = 1; s < 4; s++) if (nm[s] < nm[mBest]) mBest = s;
    for (int s = 0; s < 4; s++) mSnap[dst][s] = nm[s];
    mT = dst;
  endtask

  // read back all snapshots through the read port (R9), compare to model
  task automatic checkSnaps(string tag);
    for (int t = 0; t < 8; t++) begin
      rdTime = 3'(t);
      #1;
      for (int s = 0; s < 4; s++)
        chk(int'(rdMetrics[s*4 +: 4]) == mSnap[t][s], tag, int'(rdMetrics[s*4 +: 4]), mSnap[t][s]);
    end
  endtask

  task automatic checkCore(string tag, bit expDone);
    chk(int'(timeIdx) == mT, {tag, " R5 R8 timeIdx"}, int'(timeIdx), mT);
    chk(int'(bestState) == mBest, {tag, " R4 bestState"}, int'(bestState), mBest);
    chk(stepDone == expDone, {tag, " R6 stepDone"}, int'(stepDone), int'(expDone));
  endtask

  task automatic doReset();
    rst = 1'b1;
    symValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  task automatic doStep(int sym, string tag);
    symValid = 1'b1;
    symIn = 2'(sym);
    @(negedge clk);
    symValid = 1'b0;
    modelStep(sym);
    checkCore(tag, 1'b1);
    checkSnaps({tag, " R2 R3 R5 R9 metrics"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    checkCore("R1 reset", 1'b0);
    checkSnaps("R1 reset snapshots");

    // R2 R3 R4: every three-symbol sequence from reset
    for (int seq = 0; seq < 64; seq++) begin
      doReset();
      for (int k = 0; k < 3; k++) doStep((seq >> (2 * k)) & 3, "sweep");
    end

    // R7: idle cycles with changing symIn leave everything unchanged
    doReset();
    doStep(3, "pre-idle");
    doStep(1, "pre-idle");
    for (int i = 0; i < 6; i++) begin
      symIn = 2'(i);
      @(negedge clk);
      checkCore("R7 idle", 1'b0);
    end
    checkSnaps("R7 idle snapshots");

    // R8: long stream across several window wraps
    begin
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 40; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        doStep(int'(lfsr[1:0]), (mT == 7) ? "R8 wrap" : "stream");
      end
    end

    // R8: wrap right after a constant noisy run, then back-to-back symbols
    doReset();
    for (int i = 0; i < 7; i++) doStep(2, "noisy");
    doStep(3, "R8 wrap after noisy");
    symValid = 1'b1;
    symIn = 2'd1;
    @(negedge clk);
    symIn = 2'd2;
    modelStep(1);
    checkCore("b2b", 1'b1);
    @(negedge clk);
    symValid = 1'b0;
    modelStep(2);
    checkCore("b2b", 1'b1);
    checkSnaps("b2b R5 R9 metrics");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule